// File: doc/BRIEF.md
# Latched Masked Interrupt Controller

This block gathers single-cycle event pulses from a set of upstream sources and reports them to a host processor on one active-high interrupt request line. Every source owns three bits. The status bit latches its event and holds it until the host clears it. The mask bit decides whether that status bit may drive the request line. The sense bit shows the live level of the source at the moment it is read.

The host reaches the block through a plain register port. A write to the status address clears every status bit whose data bit is 1. A write to the mask address loads the whole mask. Reads return the status, the mask or the live sense levels. The request line is registered, and it follows the latched and unmasked state at the same clock edge that updates that state.

Out of reset every source is masked except one designated boot source. A host that has not yet programmed the mask can therefore poll the status register, while the boot source can still interrupt it.

Top module: `irq_latch_top`

## Requirements
- R1: After reset the status register reads 0, the mask register reads all ones except bit BOOT_SRC (default 5), which reads 0, and irqReq is 0.
- R2: An evtPulse bit that is high at a clock edge sets the matching status bit at that edge. The bit stays set after the pulse ends, until the host clears it.
- R3: A write to address 0 clears each status bit whose regWrData bit is 1. Status bits whose regWrData bit is 0 keep their value.
- R4: When an event pulse and a clear write hit the same status bit at the same edge, the bit is set after that edge.
- R5: After every clock edge, irqReq equals the OR over all bits of (status AND NOT mask), using the status and mask values that this edge produced.
- R6: A masked source still latches its status bit, and the host can read that bit, but the source does not raise irqReq.
- R7: A mask write that clears the mask bit of an already latched status bit raises irqReq at the edge where the mask takes the new value.
- R8: If the host clears one pending bit at the same edge that an unmasked event on another bit is latched, irqReq stays 1 with no low cycle.
- R9: A read of address 2 returns the current senseLvl input in the same cycle, combinationally. A write to address 2 changes neither status nor mask.
- R10: A read of address 0 returns status and a read of address 1 returns mask. Address 3 reads as 0, and a write to address 3 is ignored.
- R11: A write to address 1 replaces all mask bits with regWrData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evtPulse | input | NUM_SRC | One-cycle event pulses, one per source |
| senseLvl | input | NUM_SRC | Live source levels |
| regAddr | input | 2 | Register address: 0 status, 1 mask, 2 sense |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | NUM_SRC | Write data |
| regRdData | output | NUM_SRC | Read data for regAddr, combinational |
| irqReq | output | 1 | Registered interrupt request, active high |

## Verification
Two actions can land on the same edge. The first is an upstream event pulse together with a host clear aimed at the same bit. The second is a clear of one bit together with a fresh event on its neighbour. The bench drives both actions in a single cycle for every one of the sixteen bit positions. For the first case it expects the bit still set after the edge. For the second it expects irqReq to stay 1 and the status register to hold only the neighbour's bit.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_SENSE  = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    clrStatus;
    logic    loadMask;
    regSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctlStrobe_t        strobe
);

  regSel_e addrSel;

  always_comb begin
    addrSel = regSel_e'(regAddr);
    strobe.clrStatus = regWrEn && (addrSel == SEL_STATUS);
    strobe.loadMask  = regWrEn && (addrSel == SEL_MASK);
    strobe.rdSel     = addrSel;
  end

endmodule

// File: rtl/irq_latch_dp.sv
module irq_latch_dp
  import irq_latch_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int BOOT_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctlStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic [NUM_SRC-1:0] senseLvl,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqReq
);

  localparam logic [NUM_SRC-1:0] BOOT_BIT = NUM_SRC'(1) << BOOT_SRC;
  localparam logic [NUM_SRC-1:0] MASK_RST = ~BOOT_BIT;

  logic [NUM_SRC-1:0] statusQ, statusNext;
  logic [NUM_SRC-1:0] maskQ, maskNext;
  logic [NUM_SRC-1:0] clrVec;
  logic [NUM_SRC-1:0] pendNext;

  assign clrVec   = strobe.clrStatus ? wrData : '0;
  assign maskNext = strobe.loadMask ? wrData : maskQ;

  // Per-source latch: an event outranks a clear on the same bit.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_comb begin
      statusNext[i] = (statusQ[i] && !clrVec[i]) || evtPulse[i];
      pendNext[i]   = statusNext[i] && !maskNext[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusQ <= '0;
      maskQ   <= MASK_RST;
      irqReq  <= 1'b0;
    end else begin
      statusQ <= statusNext;
      maskQ   <= maskNext;
      irqReq  <= |pendNext;
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_STATUS: rdData = statusQ;
      SEL_MASK:   rdData = maskQ;
      SEL_SENSE:  rdData = senseLvl;
      default:    rdData = '0;
    endcase
  end

  // R2: a pulsed bit reads as set after the edge
  assert_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evtPulse) |=> ((statusQ & $past(evtPulse)) == $past(evtPulse)));

  // R3: cleared bits without a competing event drop to 0
  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clrVec & ~evtPulse) != '0) |=> ((statusQ & $past(clrVec & ~evtPulse)) == '0));

  // R3: bits neither cleared nor pulsed keep their value
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(clrVec | evtPulse))) |=> (statusQ == $past(statusQ)));

  // R4: an event wins against a clear on the same bit
  assert_race_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((clrVec & evtPulse) != '0) |=> ((statusQ & $past(clrVec & evtPulse)) == $past(clrVec & evtPulse)));

  // R5: the request never rises without a latched, unmasked bit
  assert_req_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> (|(statusQ & ~maskQ)));

  // R8: an unmasked event keeps or raises the request
  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(evtPulse & ~maskQ)) && !strobe.loadMask) |=> irqReq);

  // R11: a mask write loads the whole word
  assert_mask_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadMask |=> (maskQ == $past(wrData)));

endmodule

// File: rtl/irq_latch_top.sv
module irq_latch_top
  import irq_latch_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int BOOT_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic [NUM_SRC-1:0] senseLvl,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [NUM_SRC-1:0] regRdData,
  output logic               irqReq
);

  ctlStrobe_t strobe;

  irq_latch_ctrl ctrl_i (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  irq_latch_dp #(
    .NUM_SRC  (NUM_SRC),
    .BOOT_SRC (BOOT_SRC)
  ) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .wrData   (regWrData),
    .evtPulse (evtPulse),
    .senseLvl (senseLvl),
    .rdData   (regRdData),
    .irqReq   (irqReq)
  );

endmodule

// File: tb/irq_latch_top_tb_top.sv
module irq_latch_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 16;
  localparam int BOOT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] evtPulse = '0;
  logic [NSRC-1:0] senseLvl = '0;
  logic [NSRC-1:0] regWrData = '0;
  logic [1:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [NSRC-1:0] regRdData;
  logic irqReq;

  int checks = 0;
  int failures = 0;
  logic [NSRC-1:0] expStatus;
  logic [NSRC-1:0] expMask;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_latch_top #(.NUM_SRC(NSRC), .BOOT_SRC(BOOT)) dut_i (
    .clk(clk), .rst_n(rst_n), .evtPulse(evtPulse), .senseLvl(senseLvl),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqReq(irqReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic expIrq();
    return |(expStatus & ~expMask);
  endfunction

  // Drive at a falling edge, take one rising edge, update the model, return at the next falling edge.
  task automatic step(input logic [NSRC-1:0] evt, input logic wen,
                      input logic [1:0] addr, input logic [NSRC-1:0] data);
    evtPulse = evt; regWrEn = wen; regAddr = addr; regWrData = data;
    @(posedge clk); #1;
    if (wen && addr == 2'd0) expStatus = expStatus & ~data;
    expStatus = expStatus | evt;
    if (wen && addr == 2'd1) expMask = data;
    evtPulse = '0; regWrEn = 1'b0; regWrData = '0;
    @(negedge clk);
  endtask

  task automatic checkState(input string req);
    regAddr = 2'd0; #1;
    chk({req, " status"}, 32'(regRdData), 32'(expStatus));
    regAddr = 2'd1; #1;
    chk({req, " mask"}, 32'(regRdData), 32'(expMask));
    chk({req, " irq"}, 32'(irqReq), 32'(expIrq()));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    expStatus = '0;
    expMask = ~(NSRC'(1) << BOOT);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkState("R1 reset");

    // Boot source interrupts out of reset
    step(NSRC'(1) << BOOT, 1'b0, 2'd0, '0);
    checkState("R1 boot unmasked");
    step('0, 1'b1, 2'd0, '1);
    checkState("R3 clear all");

    for (int i = 0; i < NSRC; i++) begin
      logic [NSRC-1:0] bitI;
      bitI = NSRC'(1) << i;
      step('0, 1'b1, 2'd1, '1);
      checkState("R11 mask all");
      step(bitI, 1'b0, 2'd0, '0);
      checkState("R6 masked latch");
      step('0, 1'b0, 2'd0, '0);
      checkState("R2 holds after pulse");
      step('0, 1'b1, 2'd1, ~bitI);
      checkState("R7 unmask raises");
      step('0, 1'b1, 2'd0, '0);
      checkState("R3 zero write keeps");
      step('0, 1'b1, 2'd0, bitI);
      checkState("R3 clear drops irq");
      step(bitI, 1'b1, 2'd0, bitI);
      checkState("R4 event wins");
      step('0, 1'b1, 2'd0, bitI);
      checkState("R5 idle after clear");
    end

    // Multi-bit patterns
    step('0, 1'b1, 2'd1, 16'h00FF);
    step('1, 1'b0, 2'd0, '0);
    checkState("R5 all pending");
    step('0, 1'b1, 2'd0, 16'hFF00);
    checkState("R5 only masked left");
    step('0, 1'b1, 2'd0, 16'hA5A5);
    checkState("R3 partial clear");
    step('0, 1'b1, 2'd0, '1);
    checkState("R3 empty");

    // Clear one bit while another latches
    step('0, 1'b1, 2'd1, '0);
    for (int i = 0; i < NSRC; i++) begin
      logic [NSRC-1:0] bitA, bitB;
      bitA = NSRC'(1) << i;
      bitB = NSRC'(1) << ((i + 1) % NSRC);
      step(bitA, 1'b0, 2'd0, '0);
      step(bitB, 1'b1, 2'd0, bitA);
      chk("R8 irq stays high", 32'(irqReq), 32'd1);
      checkState("R8 state");
      step('0, 1'b1, 2'd0, bitB);
      checkState("R8 cleanup");
    end

    // Sense reads
    for (int k = 0; k < NSRC; k++) begin
      senseLvl = (NSRC'(1) << k) ^ 16'h0F0F;
      regAddr = 2'd2; #1;
      chk("R9 sense read", 32'(regRdData), 32'((NSRC'(1) << k) ^ 16'h0F0F));
      @(negedge clk);
    end
    step(16'h0011, 1'b1, 2'd1, 16'h0100);
    step('0, 1'b1, 2'd2, '1);
    checkState("R9 sense write ignored");
    regAddr = 2'd3; #1;
    chk("R10 addr3 reads zero", 32'(regRdData), 32'd0);
    step('0, 1'b1, 2'd3, '1);
    checkState("R10 addr3 write ignored");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule